// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous dual-port memory of 16-bit words. A left port and a right port each carry a chip select, a write enable, an output enable, two byte selects, an address and separate write and read data buses. Each port can read or write any word on each clock edge, independently of the other. Read data is registered. A per-byte drive flag tells the surrounding logic which byte lanes of the read bus carry valid data.

When both ports select the same word in the same cycle, the left port wins. The right port sees a combinational busy flag, and any write it attempts in that cycle is dropped.

The two highest words act as mailboxes between the ports. A left write to the top word raises the right port's interrupt, and a right read of that word clears it. The word just below the top works the same way in the other direction and drives the left port's interrupt.

Top module: `dpram_mbox`

## Requirements
- R1: After reset, both interrupt flags and both per-byte drive flags are 0, and both read buses read 0.
- R2: A write (chip select and write enable high) updates only the byte lanes whose select is high: the upper select covers bits 15..8 and the lower select covers bits 7..0. The other lanes keep their old contents.
- R3: A read (chip select and output enable high, write enable low) returns the word on the clock edge after the request. Drive bit 1 follows the upper select and drive bit 0 follows the lower select. An unselected lane reads 0.
- R4: With output enable low, or chip select low, or during a write, a port's drive flag is 2'b00 and its read bus is 0 in the following cycle.
- R5: The right busy flag is high in the same cycle whenever both chip selects are high and the two addresses are equal. Otherwise it is low. The left busy flag is always low.
- R6: A right write made while the right busy flag is high leaves memory unchanged, while a simultaneous left write to that word takes effect.
- R7: A read of a word that the other port writes in the same cycle returns the old contents. The new contents are returned by reads from the next cycle onward.
- R8: A left write to address DEPTH-1 sets the right interrupt from the next cycle. A right read of DEPTH-1 clears it from the next cycle.
- R9: A right write to address DEPTH-2 that is not blocked sets the left interrupt from the next cycle. A left read of DEPTH-2 clears it from the next cycle.
- R10: If a set and a clear of the same interrupt happen in the same cycle, the set wins. An interrupt flag stays unchanged when neither happens.
- R11: The mailbox words also store their data, and the interrupt-clearing read returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs | input | 1 | Left chip select |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper byte select (bits 15..8) |
| l_lb | input | 1 | Left lower byte select (bits 7..0) |
| l_addr | input | AW | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, registered |
| l_drive | output | 2 | Left lane valid flags {upper, lower} |
| l_busy | output | 1 | Left busy flag (left always wins) |
| l_irq | output | 1 | Left interrupt flag |
| r_cs | input | 1 | Right chip select |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper byte select (bits 15..8) |
| r_lb | input | 1 | Right lower byte select (bits 7..0) |
| r_addr | input | AW | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, registered |
| r_drive | output | 2 | Right lane valid flags {upper, lower} |
| r_busy | output | 1 | Right busy flag, combinational |
| r_irq | output | 1 | Right interrupt flag |

## Verification
The hardest case to reach is a set and a clear of one interrupt in the same cycle, because the two ports must meet on the mailbox word itself. That also raises busy, so arbitration and the mailbox logic interact. The bench first leaves the right interrupt pending. It then drives a left write and a right read of the top word in one cycle and checks that the flag stays set, that the read returns the old word, and that a later read clears the flag. The same-cycle stale read is reached by presetting a word and then driving a left write and a right read of it together.

// File: rtl/dpram_mbox.sv
module dpram_mbox #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic          l_ub,
  input  logic          l_lb,
  input  logic [AW-1:0] l_addr,
  input  logic [15:0]   l_wdata,
  output logic [15:0]   l_rdata,
  output logic [1:0]    l_drive,
  output logic          l_busy,
  output logic          l_irq,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic          r_ub,
  input  logic          r_lb,
  input  logic [AW-1:0] r_addr,
  input  logic [15:0]   r_wdata,
  output logic [15:0]   r_rdata,
  output logic [1:0]    r_drive,
  output logic          r_busy,
  output logic          r_irq
);
  localparam logic [AW-1:0] BOX_TO_R = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BOX_TO_L = AW'(DEPTH - 2);

  logic [15:0] mem [DEPTH];

  assign r_busy = l_cs & r_cs & (l_addr == r_addr);
  assign l_busy = 1'b0;

  wire l_wr = l_cs & l_we & (l_ub | l_lb);
  wire r_wr = r_cs & r_we & (r_ub | r_lb) & ~r_busy;
  wire l_rd = l_cs & l_oe & ~l_we;
  wire r_rd = r_cs & r_oe & ~r_we;

  wire r_irq_set = l_wr & (l_addr == BOX_TO_R);
  wire r_irq_clr = r_rd & (r_addr == BOX_TO_R);
  wire l_irq_set = r_wr & (r_addr == BOX_TO_L);
  wire l_irq_clr = l_rd & (l_addr == BOX_TO_L);

  always_ff @(posedge clk) begin
    if (l_wr && l_ub) mem[l_addr][15:8] <= l_wdata[15:8];
    if (l_wr && l_lb) mem[l_addr][7:0]  <= l_wdata[7:0];
    if (r_wr && r_ub) mem[r_addr][15:8] <= r_wdata[15:8];
    if (r_wr && r_lb) mem[r_addr][7:0]  <= r_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      l_drive <= '0;
      r_rdata <= '0;
      r_drive <= '0;
    end else begin
      l_drive <= {l_rd & l_ub, l_rd & l_lb};
      r_drive <= {r_rd & r_ub, r_rd & r_lb};
      l_rdata <= {(l_rd & l_ub) ? mem[l_addr][15:8] : 8'h00,
                  (l_rd & l_lb) ? mem[l_addr][7:0]  : 8'h00};
      r_rdata <= {(r_rd & r_ub) ? mem[r_addr][15:8] : 8'h00,
                  (r_rd & r_lb) ? mem[r_addr][7:0]  : 8'h00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_irq <= 1'b0;
      r_irq <= 1'b0;
    end else begin
      if (r_irq_set)      r_irq <= 1'b1;
      else if (r_irq_clr) r_irq <= 1'b0;
      if (l_irq_set)      l_irq <= 1'b1;
      else if (l_irq_clr) l_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dpram_mbox_chk.sv
module dpram_mbox_chk #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_cs,
  input logic          l_we,
  input logic          l_oe,
  input logic          l_ub,
  input logic          l_lb,
  input logic [AW-1:0] l_addr,
  input logic [1:0]    l_drive,
  input logic          l_irq,
  input logic          r_cs,
  input logic          r_we,
  input logic          r_oe,
  input logic          r_ub,
  input logic          r_lb,
  input logic [AW-1:0] r_addr,
  input logic          r_busy,
  input logic          r_irq
);
  localparam logic [AW-1:0] TOPW = AW'(DEPTH - 1);
  localparam logic [AW-1:0] NXTW = AW'(DEPTH - 2);

  p_drive_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs && l_oe && !l_we) |=> l_drive == {$past(l_ub), $past(l_lb)});

  p_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_cs && l_oe && !l_we) |=> l_drive == 2'b00);

  p_busy_needs_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |-> (l_cs && r_cs));

  p_rirq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs && l_we && (l_ub || l_lb) && l_addr == TOPW) |=> r_irq);

  p_rirq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cs && r_oe && !r_we && r_addr == TOPW &&
     !(l_cs && l_we && (l_ub || l_lb) && l_addr == TOPW)) |=> !r_irq);

  p_lirq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cs && r_we && (r_ub || r_lb) && r_addr == NXTW && !r_busy) |=> l_irq);

  p_rirq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_irq && !(r_cs && r_oe && !r_we && r_addr == TOPW)) |=> r_irq);
endmodule

bind dpram_mbox dpram_mbox_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
  .l_addr(l_addr), .l_drive(l_drive), .l_irq(l_irq),
  .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
  .r_addr(r_addr), .r_busy(r_busy), .r_irq(r_irq)
);

// File: tb/test_dpram_mbox.sv
module test_dpram_mbox;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] TOPW = AW'(DEPTH - 1);
  localparam logic [AW-1:0] NXTW = AW'(DEPTH - 2);

  logic clk = 0, rst_n = 0;
  logic l_cs = 0, l_we = 0, l_oe = 0, l_ub = 0, l_lb = 0;
  logic r_cs = 0, r_we = 0, r_oe = 0, r_ub = 0, r_lb = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_wdata = '0, r_wdata = '0;
  logic [15:0] l_rdata, r_rdata;
  logic [1:0] l_drive, r_drive;
  logic l_busy, l_irq, r_busy, r_irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dpram_mbox #(.DEPTH(DEPTH)) i_dpram_mbox (
    .clk(clk), .rst_n(rst_n),
    .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
    .l_busy(l_busy), .l_irq(l_irq),
    .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive),
    .r_busy(r_busy), .r_irq(r_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_cs = 0; l_we = 0; l_oe = 0; l_ub = 0; l_lb = 0;
    r_cs = 0; r_we = 0; r_oe = 0; r_ub = 0; r_lb = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lset(input logic we, input logic oe, input logic ub, input logic lb,
                      input logic [AW-1:0] a, input logic [15:0] d);
    l_cs = 1; l_we = we; l_oe = oe; l_ub = ub; l_lb = lb; l_addr = a; l_wdata = d;
  endtask

  task automatic rset(input logic we, input logic oe, input logic ub, input logic lb,
                      input logic [AW-1:0] a, input logic [15:0] d);
    r_cs = 1; r_we = we; r_oe = oe; r_ub = ub; r_lb = lb; r_addr = a; r_wdata = d;
  endtask

  task automatic t_reset();
    chk("R1 l_irq", l_irq, 0);
    chk("R1 r_irq", r_irq, 0);
    chk("R1 l_drive", l_drive, 0);
    chk("R1 r_drive", r_drive, 0);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
  endtask

  task automatic t_bytes();
    idle(); lset(1, 0, 1, 1, 10'h010, 16'hABCD); step();
    idle(); rset(1, 0, 1, 0, 10'h010, 16'h1234); step();
    idle(); lset(0, 1, 1, 0, 10'h010, 0); step();
    chk("R3 upper lane only", l_rdata, 16'h1200);
    chk("R3 drive upper", l_drive, 2'b10);
    idle(); rset(0, 1, 1, 1, 10'h010, 0); step();
    chk("R2 byte merge", r_rdata, 16'h12CD);
    chk("R3 drive both", r_drive, 2'b11);
    idle(); lset(0, 1, 0, 1, 10'h010, 0); step();
    chk("R3 lower lane only", l_rdata, 16'h00CD);
  endtask

  task automatic t_oe();
    idle(); lset(0, 0, 1, 1, 10'h010, 0); step();
    chk("R4 oe low drive", l_drive, 0);
    chk("R4 oe low data", l_rdata, 0);
    idle(); rset(1, 1, 1, 1, 10'h011, 16'h7777); step();
    chk("R4 write no drive", r_drive, 0);
  endtask

  task automatic t_busy();
    idle(); lset(1, 0, 1, 1, 10'h020, 16'h1111); step();
    idle(); lset(1, 0, 1, 1, 10'h020, 16'h2222); rset(1, 0, 1, 1, 10'h020, 16'h3333);
    #1;
    chk("R5 right busy", r_busy, 1);
    chk("R5 left never busy", l_busy, 0);
    step();
    idle(); lset(0, 1, 1, 1, 10'h020, 0); rset(0, 1, 1, 1, 10'h021, 0);
    #1;
    chk("R5 no busy diff addr", r_busy, 0);
    step();
    chk("R6 left write won", l_rdata, 16'h2222);
    idle(); lset(1, 0, 1, 1, 10'h020, 16'h4444); rset(0, 1, 1, 1, 10'h020, 0); step();
    chk("R7 old data same cycle", r_rdata, 16'h2222);
    idle(); rset(0, 1, 1, 1, 10'h020, 0); step();
    chk("R7 new data next cycle", r_rdata, 16'h4444);
  endtask

  task automatic t_mbox_right();
    idle(); lset(1, 0, 1, 1, TOPW, 16'h5A5A); step();
    chk("R8 right irq set", r_irq, 1);
    chk("R8 left irq untouched", l_irq, 0);
    idle(); step();
    chk("R10 right irq holds", r_irq, 1);
    idle(); rset(0, 1, 1, 1, TOPW, 0); step();
    chk("R11 mailbox data", r_rdata, 16'h5A5A);
    chk("R8 right irq cleared", r_irq, 0);
  endtask

  task automatic t_mbox_left();
    idle(); rset(1, 0, 1, 1, NXTW, 16'hC3C3); step();
    chk("R9 left irq set", l_irq, 1);
    chk("R9 right irq untouched", r_irq, 0);
    idle(); lset(0, 1, 1, 1, NXTW, 0); step();
    chk("R11 mailbox data left", l_rdata, 16'hC3C3);
    chk("R9 left irq cleared", l_irq, 0);
    idle(); lset(0, 1, 1, 1, NXTW, 0); rset(1, 0, 1, 1, NXTW, 16'h0001); step();
    chk("R9 blocked write no irq", l_irq, 0);
  endtask

  task automatic t_prio();
    idle(); lset(1, 0, 1, 1, TOPW, 16'h1357); step();
    idle(); lset(1, 0, 1, 1, TOPW, 16'h2468); rset(0, 1, 1, 1, TOPW, 0); step();
    chk("R10 set beats clear", r_irq, 1);
    chk("R7 mailbox old data", r_rdata, 16'h1357);
    idle(); rset(0, 1, 1, 1, TOPW, 0); step();
    chk("R10 later clear", r_irq, 0);
    chk("R11 newest mailbox word", r_rdata, 16'h2468);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_oe();
    t_busy();
    t_mbox_right();
    t_mbox_left();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule